// File: doc/BRIEF.md
# Unit-to-Register Dependency Matrix

This block keeps, for every function unit, a record of which architectural registers the unit's current instruction will read and which register it will write. The registers are stored in one-hot form. Each function unit owns one fixed row in a read plane and one fixed row in a write plane, and each register has its own column in both planes. Because the row is tied to the unit, the row also identifies the unit that will produce the result.

When an instruction is issued, its two source register numbers and its destination register number are decoded to single bits. Those bits are written into the row of the target unit. The block ORs each column across all rows. This produces a read-pending vector and a write-pending vector with one bit per register. Hazard logic uses these vectors, and the inverse of each column (a NOR) tells when that register is free. The block also exposes each unit's own read mask and write mask.

Rows are cleared by two per-unit strobes: one when the unit has read its operands, and one when its result has been committed. An issue is refused when its destination already has a write pending from a different unit. A refused issue leaves the matrix unchanged.

Top module: `fu_reg_matrix`

## Requirements
- R1: After reset, every row of both planes is zero, so both pending vectors and all per-unit masks read zero.
- R2: An accepted issue replaces the target unit's read row with one bit per enabled source register. A source whose enable is low adds no bit, and two equal sources give a single bit.
- R3: An accepted issue with the destination enabled replaces the target unit's write row with a single bit at the destination number. With the destination disabled, the write row becomes zero.
- R4: Bit r of the read-pending vector is the OR of column r over all read rows, and bit r of the write-pending vector is the OR of column r over all write rows. Both vectors update on the clock edge that follows the change.
- R5: The refusal output is high in the same cycle whenever issue valid is high, the destination is enabled, and a unit other than the target has that destination bit in its write row. A refused issue changes no row.
- R6: A high bit u of the operands-read strobe clears unit u's read row on the next edge and leaves its write row intact.
- R7: A high bit u of the commit strobe clears unit u's write row on the next edge and leaves its read row intact.
- R8: When an issue and a clear strobe target the same unit in the same cycle, the issue takes effect. The refusal check uses the matrix contents from before that edge.
- R9: While issue valid is low, the refusal output is low and no row gains any bit.
- R10: A destination that is write-pending only in the target unit's own row does not cause refusal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request this cycle |
| issue_unit | input | UNIT_W | Target function unit number |
| src_a_en | input | 1 | First source register is used |
| src_a | input | REG_W | First source register number |
| src_b_en | input | 1 | Second source register is used |
| src_b | input | REG_W | Second source register number |
| dst_en | input | 1 | Destination register is used |
| dst | input | REG_W | Destination register number |
| opnd_read | input | NUM_UNITS | Per unit: operands have been read, clear read row |
| result_commit | input | NUM_UNITS | Per unit: result committed, clear write row |
| issue_refused | output | 1 | Issue blocked by another unit's pending write to dst |
| read_pending | output | NUM_REGS | Per register: some unit will read it |
| write_pending | output | NUM_REGS | Per register: some unit will write it |
| unit_rd_mask | output | NUM_UNITS*NUM_REGS | Read rows concatenated, unit u at bits u*NUM_REGS upward |
| unit_wr_mask | output | NUM_UNITS*NUM_REGS | Write rows concatenated, unit u at bits u*NUM_REGS upward |

## Verification
The bench goes after four corner cases. The first is a destination that another unit is still writing. A design that ignores the conflict would let two writers hold the same register, and a design that refuses but still writes would corrupt the matrix. The second is an issue to a unit whose own write is pending. A design that counted its own row would block a legal reissue. The third is an issue landing together with a clear strobe for the same unit. A design that let the clear win would lose the new instruction's registers. The bench also checks that duplicate sources, disabled fields, and the registers at both ends of the range (0 and 31) set exactly the expected bits, because an off-by-one decoder would mark the wrong column.

// File: rtl/fu_reg_matrix.sv
module fu_reg_matrix #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 32,
  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int REG_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue_valid,
  input  logic [UNIT_W-1:0]             issue_unit,
  input  logic                          src_a_en,
  input  logic [REG_W-1:0]              src_a,
  input  logic                          src_b_en,
  input  logic [REG_W-1:0]              src_b,
  input  logic                          dst_en,
  input  logic [REG_W-1:0]              dst,
  input  logic [NUM_UNITS-1:0]          opnd_read,
  input  logic [NUM_UNITS-1:0]          result_commit,
  output logic                          issue_refused,
  output logic [NUM_REGS-1:0]           read_pending,
  output logic [NUM_REGS-1:0]           write_pending,
  output logic [NUM_UNITS*NUM_REGS-1:0] unit_rd_mask,
  output logic [NUM_UNITS*NUM_REGS-1:0] unit_wr_mask
);

  logic [NUM_REGS-1:0] rd_row [NUM_UNITS];
  logic [NUM_REGS-1:0] wr_row [NUM_UNITS];
  logic [NUM_REGS-1:0] rd_bits, wr_bits;
  logic                conflict, accept;

  assign rd_bits = ({{(NUM_REGS-1){1'b0}}, src_a_en} << src_a)
                 | ({{(NUM_REGS-1){1'b0}}, src_b_en} << src_b);
  assign wr_bits = {{(NUM_REGS-1){1'b0}}, dst_en} << dst;

  always_comb begin
    conflict = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (u[UNIT_W-1:0] != issue_unit && wr_row[u][dst]) conflict = 1'b1;
  end

  assign issue_refused = issue_valid && dst_en && conflict;
  assign accept        = issue_valid && !issue_refused;

  always_comb begin
    read_pending  = '0;
    write_pending = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      read_pending  = read_pending  | rd_row[u];
      write_pending = write_pending | wr_row[u];
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_row
    logic hit;
    assign hit = accept && issue_unit == u;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_row[u] <= '0;
        wr_row[u] <= '0;
      end else if (hit) begin
        rd_row[u] <= rd_bits;
        wr_row[u] <= wr_bits;
      end else begin
        if (opnd_read[u])     rd_row[u] <= '0;
        if (result_commit[u]) wr_row[u] <= '0;
      end
    end

    assign unit_rd_mask[u*NUM_REGS +: NUM_REGS] = rd_row[u];
    assign unit_wr_mask[u*NUM_REGS +: NUM_REGS] = wr_row[u];

    // R3
    wr_row_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_row[u]));
  end

  // R2
  src_a_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_refused && src_a_en |=> read_pending[$past(src_a)]);

  // R3
  dst_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_refused && dst_en |=> write_pending[$past(dst)]);

  // R5
  refuse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_refused |-> issue_valid && dst_en && write_pending[dst]);

  // R6
  all_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&opnd_read) && !issue_valid |=> read_pending == '0);

  // R7
  all_commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&result_commit) && !issue_valid |=> write_pending == '0);

  // R9
  idle_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (write_pending & ~$past(write_pending)) == '0);

endmodule

// File: tb/fu_reg_matrix_tb_top.sv
module fu_reg_matrix_tb_top;
  localparam int NU = 4;
  localparam int NR = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [1:0] issue_unit = '0;
  logic src_a_en = 1'b0, src_b_en = 1'b0, dst_en = 1'b0;
  logic [4:0] src_a = '0, src_b = '0, dst = '0;
  logic [NU-1:0] opnd_read = '0, result_commit = '0;
  logic issue_refused;
  logic [NR-1:0] read_pending, write_pending;
  logic [NU*NR-1:0] unit_rd_mask, unit_wr_mask;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fu_reg_matrix #(.NUM_UNITS(NU), .NUM_REGS(NR)) dut_i (
    .clk, .rst_n, .issue_valid, .issue_unit, .src_a_en, .src_a, .src_b_en,
    .src_b, .dst_en, .dst, .opnd_read, .result_commit, .issue_refused,
    .read_pending, .write_pending, .unit_rd_mask, .unit_wr_mask
  );

  typedef struct packed {
    logic        v;
    logic [1:0]  unit;
    logic        ae;
    logic [4:0]  a;
    logic        be;
    logic [4:0]  b;
    logic        de;
    logic [4:0]  d;
    logic [3:0]  rdd;
    logic [3:0]  wrd;
    logic        refused;
    logic [31:0] rdp;
    logic [31:0] wrp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 1'b1, 5'd1,  1'b1, 5'd2, 1'b1, 5'd3,  4'h0, 4'h0, 1'b0, 32'h0000_0006, 32'h0000_0008},
    '{1'b1, 2'd1, 1'b1, 5'd3,  1'b1, 5'd3, 1'b1, 5'd5,  4'h0, 4'h0, 1'b0, 32'h0000_000E, 32'h0000_0028},
    '{1'b1, 2'd2, 1'b1, 5'd4,  1'b0, 5'd0, 1'b1, 5'd3,  4'h0, 4'h0, 1'b1, 32'h0000_000E, 32'h0000_0028},
    '{1'b1, 2'd2, 1'b1, 5'd4,  1'b0, 5'd0, 1'b0, 5'd3,  4'h0, 4'h0, 1'b0, 32'h0000_001E, 32'h0000_0028},
    '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 5'd0, 1'b0, 5'd0,  4'h1, 4'h0, 1'b0, 32'h0000_0018, 32'h0000_0028},
    '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 5'd0, 1'b0, 5'd0,  4'h0, 4'h1, 1'b0, 32'h0000_0018, 32'h0000_0020},
    '{1'b1, 2'd3, 1'b1, 5'd31, 1'b1, 5'd0, 1'b1, 5'd3,  4'h0, 4'h0, 1'b0, 32'h8000_0019, 32'h0000_0028},
    '{1'b1, 2'd1, 1'b1, 5'd6,  1'b0, 5'd0, 1'b1, 5'd7,  4'h2, 4'h0, 1'b0, 32'h8000_0051, 32'h0000_0088},
    '{1'b1, 2'd0, 1'b0, 5'd0,  1'b0, 5'd0, 1'b1, 5'd7,  4'h0, 4'h2, 1'b1, 32'h8000_0051, 32'h0000_0008},
    '{1'b1, 2'd0, 1'b1, 5'd5,  1'b1, 5'd5, 1'b1, 5'd31, 4'hC, 4'h8, 1'b0, 32'h0000_0060, 32'h8000_0000},
    '{1'b0, 2'd2, 1'b1, 5'd9,  1'b0, 5'd0, 1'b1, 5'd31, 4'h0, 4'h0, 1'b0, 32'h0000_0060, 32'h8000_0000}
  };

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(vec_t e);
    issue_valid = e.v; issue_unit = e.unit;
    src_a_en = e.ae; src_a = e.a; src_b_en = e.be; src_b = e.b;
    dst_en = e.de; dst = e.d; opnd_read = e.rdd; result_commit = e.wrd;
  endtask

  task automatic idle();
    drive('0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 read_pending", read_pending, '0);
    check("R1 write_pending", write_pending, '0);
    check("R1 masks", {unit_rd_mask, unit_wr_mask}, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      // R5 R9 R10 refusal is combinational
      check($sformatf("R5 refused row %0d", i), issue_refused, VEC[i].refused);
      @(posedge clk);
      #1;
      // R2 R4 R6 R8 read plane
      check($sformatf("R4 read_pending row %0d", i), read_pending, VEC[i].rdp);
      // R3 R7 write plane
      check($sformatf("R4 write_pending row %0d", i), write_pending, VEC[i].wrp);
    end

    @(negedge clk);
    idle();
    #1;
    // R2 duplicate source gives one bit; R8 overwrite
    check("R2 unit0 read mask", unit_rd_mask[0 +: NR], 32'h0000_0020);
    check("R3 unit0 write mask", unit_wr_mask[0 +: NR], 32'h8000_0000);
    check("R8 unit1 read mask", unit_rd_mask[NR +: NR], 32'h0000_0040);
    check("R7 unit1 write cleared", unit_wr_mask[NR +: NR], 32'h0);

    // R10 reissue to own unit with own pending destination
    issue_valid = 1'b1; issue_unit = 2'd0; dst_en = 1'b1; dst = 5'd31;
    src_a_en = 1'b0; src_b_en = 1'b0;
    #1;
    check("R10 own-unit not refused", issue_refused, 1'b0);
    @(posedge clk); #1;
    check("R3 write row kept dst 31", unit_wr_mask[0 +: NR], 32'h8000_0000);
    check("R2 disabled sources no bits", unit_rd_mask[0 +: NR], 32'h0);

    // R5 other unit same dst refused, unit3 row unchanged
    @(negedge clk);
    issue_unit = 2'd3; src_a_en = 1'b1; src_a = 5'd12;
    #1;
    check("R5 other unit refused", issue_refused, 1'b1);
    @(posedge clk); #1;
    check("R5 refused leaves row", unit_rd_mask[3*NR +: NR], 32'h0);

    // R6 read clear keeps write row
    @(negedge clk);
    idle(); opnd_read = 4'hF;
    @(posedge clk); #1;
    check("R6 reads cleared", read_pending, 32'h0);
    check("R6 write kept", write_pending, 32'h8000_0000);

    // R1 mid-run reset
    @(negedge clk);
    idle(); issue_valid = 1'b1; issue_unit = 2'd2; dst_en = 1'b1; dst = 5'd9;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 reset clears write", write_pending, 32'h0);
    check("R1 reset clears masks", {unit_rd_mask, unit_wr_mask}, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule